// File: doc/BRIEF.md
# Configuration Access Port Translator

This block connects a host I/O bus to a configuration-cycle interface using the indirect two-port method. A host first writes a full 32-bit word to the address port at I/O 0x0CF8. That word holds an enable flag and selects a bus, device, function and dword register. Host accesses to the data port at 0x0CFC–0x0CFF then become configuration read or write requests for that register. Each request carries byte enables that follow the host access size and its offset within the port.

The block stores the address word, decodes every host access and routes it. It either serves the access itself (address port), issues a configuration request, or forwards the access unchanged to the ordinary I/O path. For a configuration request it holds the host access until the target responds. It then returns the read data with the lanes that were not selected forced to zero.

A host access is a level `host_valid` held with stable fields until the one-cycle `host_done` pulse. Sizes are encoded 0 = byte, 1 = 16-bit, 2 = 32-bit, 3 = reserved. Write data and read data sit on the byte lanes given by the low two address bits.

Top module: `cfg_port_xlate`

## Requirements
- R1: A 32-bit access at offset 0 of the address port (0x0CF8) is served by the block. A write stores the word with bits 30..24 and 1..0 forced to zero. A read returns the stored word. No configuration or I/O request is issued for either.
- R2: A byte or 16-bit access, or any reserved-size access, anywhere in 0x0CF8–0x0CFB is forwarded as an I/O cycle, and the stored address word stays unchanged.
- R3: While bit 31 of the stored word is clear, any access to 0x0CFC–0x0CFF is forwarded as an I/O cycle, and no configuration request is issued.
- R4: A configuration request takes its fields from the stored word: bus = bits 23..16, device = bits 15..11, function = bits 10..8, register = bits 7..2.
- R5: The byte enables of a request are a run of 1, 2 or 4 set bits for size 0, 1 or 2, starting at bit position address[1:0]. The request write data equals the host write data with disabled lanes zeroed. The write flag follows the host access.
- R6: A data-port access whose bytes would run past 0x0CFF (offset + size in bytes > 4) is forwarded as an I/O cycle.
- R7: `cfg_valid` stays high with stable fields until `cfg_ready`. The host access completes only after `cfg_rsp_valid`.
- R8: The read data of a configuration read is the target's response with lanes outside the byte enables set to zero. Writes return zero.
- R9: Accesses outside 0x0CF8–0x0CFF are forwarded unchanged as I/O cycles, and the I/O read data is returned to the host unchanged.
- R10: After reset the stored word is zero, so translation is off and the address port reads zero.
- R11: `host_done` is a single-cycle pulse per access, and a configuration request and an I/O request are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host access pending, held until host_done |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Host I/O byte address |
| host_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit, 3 reserved |
| host_wdata | input | 32 | Lane-aligned write data |
| host_done | output | 1 | Access complete pulse |
| host_rdata | output | 32 | Read data, valid with host_done |
| io_valid | output | 1 | Forwarded I/O cycle request |
| io_write | output | 1 | Forwarded write flag |
| io_addr | output | 16 | Forwarded address |
| io_size | output | 2 | Forwarded size |
| io_wdata | output | 32 | Forwarded write data |
| io_ready | input | 1 | I/O cycle complete, io_rdata valid |
| io_rdata | input | 32 | I/O read data |
| cfg_valid | output | 1 | Configuration request valid |
| cfg_ready | input | 1 | Request accepted |
| cfg_bus | output | 8 | Bus number |
| cfg_dev | output | 5 | Device number |
| cfg_func | output | 3 | Function number |
| cfg_reg | output | 6 | Dword register number |
| cfg_be | output | 4 | Byte enables |
| cfg_write | output | 1 | Write flag |
| cfg_wdata | output | 32 | Write data, disabled lanes zero |
| cfg_rsp_valid | input | 1 | Target response valid |
| cfg_rsp_rdata | input | 32 | Target read dword |

## Verification
A corrupted stored address word shows up on the next configuration request as wrong bus, device, function or register fields. It also shows up at once on a 32-bit read-back of the address port, and a cleared enable shows up as a data-port access leaking onto the I/O path. A decode or lane fault shows in the same access as a wrong route, wrong byte enables or unmasked read lanes. A handshake fault shows as a host completion that arrives before the target's response, or as a request that drops before it is accepted.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;
  localparam logic [31:0] ADDR_KEEP = 32'h80FF_FFFC;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_CREQ = 3'd1,
    ST_CRSP = 3'd2,
    ST_IO   = 3'd3,
    ST_DONE = 3'd4
  } state_e;

  // number of bytes of a host size code, 0 for the reserved code
  function automatic logic [2:0] size_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      2'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // access stays inside one dword
  function automatic logic fits_dword(input logic [1:0] off, input logic [1:0] sz);
    logic [3:0] last;
    last = {2'b00, off} + {1'b0, size_bytes(sz)};
    return (size_bytes(sz) != 3'd0) && (last <= 4'd4);
  endfunction

  function automatic logic [3:0] lane_mask(input logic [1:0] off, input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001 << off;
      2'd1:    return 4'b0011 << off;
      2'd2:    return 4'b1111 << off;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] lanes_to_bits(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction
endpackage

// File: rtl/cfgx_addr_latch.sv
module cfgx_addr_latch
  import cfgx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] d,
  output logic [31:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else if (wr) q <= d & ADDR_KEEP;
  end

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(q));
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
  import cfgx_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic [IO_AW-1:0] addr,
  input  logic [1:0]       size,
  input  logic             cfg_en,
  output logic             hit_addr,
  output logic             hit_data,
  output logic [3:0]       be
);
  logic in_addr_dw, in_data_dw;

  assign in_addr_dw = addr[IO_AW-1:2] == ADDR_PORT[IO_AW-1:2];
  assign in_data_dw = addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2];
  assign hit_addr   = in_addr_dw && (size == 2'd2) && (addr[1:0] == 2'b00);
  assign hit_data   = in_data_dw && cfg_en && fits_dword(addr[1:0], size);
  assign be         = lane_mask(addr[1:0], size);
endmodule

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate
  import cfgx_pkg::*;
#(
  parameter int IO_AW = 16,
  parameter logic [IO_AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [IO_AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_valid,
  input  logic             host_write,
  input  logic [IO_AW-1:0] host_addr,
  input  logic [1:0]       host_size,
  input  logic [31:0]      host_wdata,
  output logic             host_done,
  output logic [31:0]      host_rdata,
  output logic             io_valid,
  output logic             io_write,
  output logic [IO_AW-1:0] io_addr,
  output logic [1:0]       io_size,
  output logic [31:0]      io_wdata,
  input  logic             io_ready,
  input  logic [31:0]      io_rdata,
  output logic             cfg_valid,
  input  logic             cfg_ready,
  output logic [7:0]       cfg_bus,
  output logic [4:0]       cfg_dev,
  output logic [2:0]       cfg_func,
  output logic [5:0]       cfg_reg,
  output logic [3:0]       cfg_be,
  output logic             cfg_write,
  output logic [31:0]      cfg_wdata,
  input  logic             cfg_rsp_valid,
  input  logic [31:0]      cfg_rsp_rdata
);
  state_e      state_q, state_d;
  logic [31:0] lat_q;
  logic        lat_wr;
  logic        hit_addr, hit_data;
  logic [3:0]  dec_be;
  logic [31:0] rdata_q;
  logic        accept;

  assign accept = (state_q == ST_IDLE) && host_valid;
  assign lat_wr = accept && hit_addr && host_write;

  cfgx_addr_latch u_latch (
    .clk(clk), .rst_n(rst_n), .wr(lat_wr), .d(host_wdata), .q(lat_q)
  );

  cfgx_decode #(.IO_AW(IO_AW), .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)) u_dec (
    .addr(host_addr), .size(host_size), .cfg_en(lat_q[31]),
    .hit_addr(hit_addr), .hit_data(hit_data), .be(dec_be)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (host_valid) begin
        if (hit_addr)      state_d = ST_DONE;
        else if (hit_data) state_d = ST_CREQ;
        else               state_d = ST_IO;
      end
      ST_CREQ: if (cfg_ready)     state_d = ST_CRSP;
      ST_CRSP: if (cfg_rsp_valid) state_d = ST_DONE;
      ST_IO:   if (io_ready)      state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rdata_q   <= '0;
      cfg_bus   <= '0;
      cfg_dev   <= '0;
      cfg_func  <= '0;
      cfg_reg   <= '0;
      cfg_be    <= '0;
      cfg_write <= 1'b0;
      cfg_wdata <= '0;
    end else begin
      state_q <= state_d;
      if (accept && hit_addr)
        rdata_q <= host_write ? 32'd0 : lat_q;
      if (accept && !hit_addr && hit_data) begin
        cfg_bus   <= lat_q[23:16];
        cfg_dev   <= lat_q[15:11];
        cfg_func  <= lat_q[10:8];
        cfg_reg   <= lat_q[7:2];
        cfg_be    <= dec_be;
        cfg_write <= host_write;
        cfg_wdata <= host_wdata & lanes_to_bits(dec_be);
      end
      if (state_q == ST_CRSP && cfg_rsp_valid)
        rdata_q <= cfg_write ? 32'd0 : (cfg_rsp_rdata & lanes_to_bits(cfg_be));
      if (state_q == ST_IO && io_ready)
        rdata_q <= host_write ? 32'd0 : io_rdata;
    end
  end

  assign cfg_valid  = state_q == ST_CREQ;
  assign io_valid   = state_q == ST_IO;
  assign host_done  = state_q == ST_DONE;
  assign host_rdata = rdata_q;
  assign io_write   = host_write;
  assign io_addr    = host_addr;
  assign io_size    = host_size;
  assign io_wdata   = host_wdata;

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_be) && $stable(cfg_reg)
      && $stable(cfg_bus) && $stable(cfg_wdata));
  // R5
  be_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> ($countones(cfg_be) == 1 || $countones(cfg_be) == 2 || $countones(cfg_be) == 4));
  // R3
  cfg_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> lat_q[31]);
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |=> !host_done);
  // R11
  req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_valid && io_valid));
endmodule

// File: tb/cfg_port_xlate_tb.sv
module cfg_port_xlate_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_write = 1'b0;
  logic [15:0] host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_done;
  logic [31:0] host_rdata;
  logic        io_valid, io_write;
  logic [15:0] io_addr;
  logic [1:0]  io_size;
  logic [31:0] io_wdata;
  logic        io_ready = 1'b0;
  logic [31:0] io_rdata = '0;
  logic        cfg_valid, cfg_write;
  logic        cfg_ready = 1'b0;
  logic [7:0]  cfg_bus;
  logic [4:0]  cfg_dev;
  logic [2:0]  cfg_func;
  logic [5:0]  cfg_reg;
  logic [3:0]  cfg_be;
  logic [31:0] cfg_wdata;
  logic        cfg_rsp_valid = 1'b0;
  logic [31:0] cfg_rsp_rdata = '0;

  cfg_port_xlate u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int cfg_cnt = 0, io_cnt = 0;
  logic [7:0]  s_bus;  logic [4:0] s_dev; logic [2:0] s_func; logic [5:0] s_reg;
  logic [3:0]  s_be;   logic s_wr; logic [31:0] s_wdata;
  logic [15:0] s_ioaddr; logic [1:0] s_iosize; logic s_iowr; logic [31:0] s_iowdata;
  logic [31:0] lat = '0;

  function automatic logic [31:0] tgt_data(logic [7:0] b, logic [4:0] d, logic [2:0] f, logic [5:0] r);
    return {r, 2'b10, f, d, b, 8'hA5};
  endfunction
  function automatic logic [31:0] io_data(logic [15:0] a);
    return {a ^ 16'h5A5A, ~a};
  endfunction
  function automatic int nbytes(logic [1:0] sz);
    return (sz == 2'd3) ? 0 : (1 << sz);
  endfunction
  function automatic logic [3:0] exp_be(logic [1:0] off, logic [1:0] sz);
    logic [3:0] m = '0;
    for (int i = 0; i < 4; i++)
      m[i] = (i >= off) && (i < int'(off) + nbytes(sz));
    return m;
  endfunction
  function automatic logic [31:0] bemask(logic [3:0] be);
    logic [31:0] m = '0;
    for (int i = 0; i < 4; i++) if (be[i]) m[i*8 +: 8] = 8'hFF;
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // configuration target model
  initial forever begin
    @(negedge clk);
    if (cfg_valid) begin
      repeat ($urandom % 3) @(negedge clk);
      s_bus = cfg_bus; s_dev = cfg_dev; s_func = cfg_func; s_reg = cfg_reg;
      s_be = cfg_be; s_wr = cfg_write; s_wdata = cfg_wdata;
      cfg_ready = 1'b1;
      @(negedge clk);
      cfg_ready = 1'b0;
      cfg_cnt++;
      repeat ($urandom % 3) @(negedge clk);
      cfg_rsp_rdata = tgt_data(s_bus, s_dev, s_func, s_reg);
      cfg_rsp_valid = 1'b1;
      @(negedge clk);
      cfg_rsp_valid = 1'b0;
    end
  end

  // plain I/O target model
  initial forever begin
    @(negedge clk);
    if (io_valid) begin
      repeat ($urandom % 3) @(negedge clk);
      s_ioaddr = io_addr; s_iosize = io_size; s_iowr = io_write; s_iowdata = io_wdata;
      io_rdata = io_data(io_addr);
      io_ready = 1'b1;
      @(negedge clk);
      io_ready = 1'b0;
      io_cnt++;
    end
  end

  task automatic access(input logic [15:0] a, input logic [1:0] sz, input logic wr,
                        input logic [31:0] wd, output logic [31:0] rd);
    host_addr = a; host_size = sz; host_write = wr; host_wdata = wd; host_valid = 1'b1;
    do @(negedge clk); while (!host_done);
    rd = host_rdata;
    host_valid = 1'b0;
  endtask

  // one access checked against the bench model
  task automatic run(input logic [15:0] a, input logic [1:0] sz, input logic wr, input logic [31:0] wd);
    int c0 = cfg_cnt, i0 = io_cnt;
    logic [31:0] rd, exp;
    logic [1:0] off = a[1:0];
    bit is_ap = (a[15:2] == 14'h033E) && sz == 2'd2 && off == 2'd0;
    bit in_ap = (a[15:2] == 14'h033E);
    bit in_dp = (a[15:2] == 14'h033F);
    bit fits  = nbytes(sz) != 0 && int'(off) + nbytes(sz) <= 4;
    access(a, sz, wr, wd, rd);
    if (is_ap) begin
      chk(cfg_cnt == c0 && io_cnt == i0, "R1 address port served locally", 32'(io_cnt - i0), 0);
      if (wr) lat = wd & 32'h80FF_FFFC;
      else chk(rd == lat, "R1 address port read", rd, lat);
    end else if (in_dp && lat[31] && fits) begin
      logic [3:0] be = exp_be(off, sz);
      chk(cfg_cnt == c0 + 1 && io_cnt == i0, "R5 data port claimed", 32'(cfg_cnt - c0), 1);
      chk({s_bus, s_dev, s_func, s_reg} == {lat[23:16], lat[15:11], lat[10:8], lat[7:2]},
          "R4 fields", {10'd0, s_bus, s_dev, s_func, s_reg}, {10'd0, lat[23:2]});
      chk(s_be == be, "R5 byte enables", {28'd0, s_be}, {28'd0, be});
      chk(s_wr == wr, "R5 write flag", {31'd0, s_wr}, {31'd0, wr});
      if (wr) chk(s_wdata == (wd & bemask(be)), "R5 write data", s_wdata, wd & bemask(be));
      exp = wr ? 32'd0 : tgt_data(lat[23:16], lat[15:11], lat[10:8], lat[7:2]) & bemask(be);
      chk(rd == exp, "R8 read lanes", rd, exp);
    end else begin
      string req = in_ap ? "R2 narrow address port forwarded" :
                   in_dp ? (lat[31] ? "R6 crossing forwarded" : "R3 disabled forwarded") :
                   "R9 other forwarded";
      chk(io_cnt == i0 + 1 && cfg_cnt == c0, req, 32'(io_cnt - i0), 1);
      chk(s_ioaddr == a && s_iosize == sz && s_iowr == wr, req, {14'd0, s_iosize, s_ioaddr}, {14'd0, sz, a});
      exp = wr ? 32'd0 : io_data(a);
      chk(rd == exp, req, rd, exp);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    void'($urandom(32'd1907));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(!host_done && !cfg_valid && !io_valid, "R10 idle after reset", {29'd0, host_done, cfg_valid, io_valid}, 0);
    access(16'h0CF8, 2'd2, 1'b0, 32'd0, rd);
    chk(rd == 32'd0, "R10 address word after reset", rd, 32'd0);
    run(16'h0CFC, 2'd2, 1'b0, 0);               // R3 disabled
    run(16'h0CF8, 2'd2, 1'b1, 32'hFFFF_FFFF);   // R1 masking
    run(16'h0CF8, 2'd2, 1'b0, 0);
    run(16'h0CF8, 2'd0, 1'b1, 32'h0000_0000);   // R2 byte write ignored
    run(16'h0CFA, 2'd1, 1'b1, 32'h0000_0000);   // R2 16-bit
    run(16'h0CF8, 2'd2, 1'b0, 0);
    run(16'h0CF8, 2'd2, 1'b1, 32'h8A5B_C9E4);   // R4 field pattern
    run(16'h0CFC, 2'd2, 1'b0, 0);
    run(16'h0CFF, 2'd0, 1'b0, 0);               // R5 single top lane
    run(16'h0CFE, 2'd1, 1'b1, 32'h1234_5678);
    run(16'h0CFF, 2'd1, 1'b0, 0);               // R6 crossing
    run(16'h0CFE, 2'd2, 1'b0, 0);               // R6
    run(16'h0CFD, 2'd3, 1'b0, 0);               // reserved size
    run(16'h0060, 2'd0, 1'b0, 0);               // R9
    run(16'h0CF4, 2'd2, 1'b1, 32'hDEAD_BEEF);   // R9
    for (int n = 0; n < 400; n++) begin
      int k = $urandom % 8;
      logic [15:0] a;
      logic [1:0] sz = 2'($urandom % 4);
      logic [31:0] wd = $urandom;
      if (k < 2) begin
        a = 16'h0CF8; sz = 2'd2;
        if ($urandom % 4 != 0) wd[31] = 1'b1;
      end else if (k < 6) a = 16'h0CFC + 16'($urandom % 4);
      else if (k == 6) a = 16'h0CF8 + 16'($urandom % 4);
      else begin
        a = 16'($urandom);
        if (a[15:3] == 13'h019F) a = a ^ 16'h0100;
      end
      run(a, sz, 1'($urandom % 2), wd);
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule